// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It walks a two-level table that lives in memory: first a directory, then one page table. Each 4096-byte page is named by the upper 20 bits of the table entry. The walker reads entries through a read port that allows one read at a time. It checks access rights on the directory entry and again on the table entry. Then it returns either the physical address or a page fault. A fault carries a cause, the level that faulted and the linear address involved.

A requester presents a linear address together with two flags. One flag says whether the access comes from user or kernel mode. The other says whether it is a read or a write. The requester may do this only while the block is not busy. The directory base and the write-protect enable come from configuration inputs and must stay stable during a walk.

Each table entry carries three flag bits. Bit 0 is present, bit 1 is writable and bit 2 is user-accessible. A kernel write to a read-only page is allowed when both of these hold: the page is marked user-accessible, and write-protect is off. Any other write to a read-only page faults.

Top module: `pt_walker`

## Requirements
- R1: During and right after reset, `busy`, `rsp_valid` and `mem_req_valid` are low.
- R2: A request is taken only when `req_valid` is high while `busy` is low. `busy` is high from the next cycle until the response cycle has passed. A `req_valid` seen while busy is ignored: it starts no walk and produces no response.
- R3: The first read goes to `root_base + 4 * lin[31:22]`.
- R4: When the directory entry passes its checks, the second read goes to `(directory entry & ~0xFFF) + 4 * lin[21:12]`.
- R5: When both entries pass, `rsp_phys_addr` = `{table entry[31:12], lin[11:0]}`. Also `rsp_fault` = 0 and `rsp_cause` = 0.
- R6: An entry whose bit 0 (present) is 0 gives a fault with cause 1 (not present). This check comes before all others.
- R7: A user access to a present entry whose bit 2 (user) is 0 gives a fault with cause 2 (privilege).
- R8: A write to a present entry that passes R7 and whose bit 1 (writable) is 0 gives cause 3 (write protection) in any of these cases: the access is from user mode, the entry's bit 2 is 0, or `wp_enable` is 1. Otherwise the write is allowed.
- R9: The checks of R6 to R8 apply to both entries. If the directory entry faults, no second read is made and `rsp_level` is 0. A fault in the table entry gives `rsp_level` = 1. On any fault, `rsp_fault_addr` holds the linear address of the request.
- R10: `rsp_valid` is high for exactly one cycle per walk. `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. Only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_lin_addr | input | 32 | Linear address to translate |
| req_user | input | 1 | 1 = user-mode access, 0 = kernel |
| req_write | input | 1 | 1 = write access, 0 = read |
| busy | output | 1 | Walk in progress; requests are not taken |
| root_base | input | 32 | Physical byte address of the directory |
| wp_enable | input | 1 | Kernel writes honour read-only pages |
| mem_req_valid | output | 1 | Read address valid |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the read address |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_fault | output | 1 | Result is a page fault |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 privilege, 3 write protection |
| rsp_level | output | 1 | Faulting level: 0 directory, 1 table |
| rsp_phys_addr | output | 32 | Translated physical address (0 on fault) |
| rsp_fault_addr | output | 32 | Linear address on a fault (0 otherwise) |

## Verification
The hardest case to reach is the kernel-write exception. It needs a present, user-accessible, read-only entry at exactly one level, hit by a kernel write. The outcome must also be seen with write-protect both off and on. Random tables seldom line up those four conditions. So the stimulus writes fixed directory and table entries and drives each flag combination directly, at both levels. Random walks over randomly filled tables run as well, with random memory ready and response delays. They also send extra requests while a walk is busy, which covers the single-outstanding and ignore rules.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // entry flag bit positions (decoded by the rights checker)
  localparam int FLAG_PRESENT = 0;
  localparam int FLAG_WRITE   = 1;
  localparam int FLAG_USER    = 2;
  localparam int FLAG_BITS    = 3;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_PRIV   = 2'd2,
    CAUSE_RO     = 2'd3
  } cause_t;

  typedef enum logic [2:0] {
    WK_IDLE, WK_DIR_RD, WK_DIR_CHK, WK_TBL_RD, WK_TBL_CHK, WK_RESP
  } walk_st_t;

  typedef enum logic [1:0] {
    RP_IDLE, RP_ADDR, RP_DATA
  } port_st_t;
endpackage

// File: rtl/ptw_rights.sv
module ptw_rights
  import ptw_pkg::*;
(
  input  logic [FLAG_BITS-1:0] flags,
  input  logic                 is_user,
  input  logic                 is_write,
  input  logic                 wp_en,
  output logic                 fault,
  output cause_t               cause
);
  logic pres, wr_ok, usr_ok;
  logic absent_evt, priv_evt, ro_evt;

  assign pres   = flags[FLAG_PRESENT];
  assign wr_ok  = flags[FLAG_WRITE];
  assign usr_ok = flags[FLAG_USER];

  assign absent_evt = !pres;
  assign priv_evt   = pres && is_user && !usr_ok;
  // read-only page: user writes always fault; kernel writes fault on
  // supervisor-only pages or when write-protect is enabled
  assign ro_evt     = pres && !priv_evt && is_write && !wr_ok &&
                      (is_user || !usr_ok || wp_en);

  always_comb begin
    if (absent_evt)    cause = CAUSE_ABSENT;
    else if (priv_evt) cause = CAUSE_PRIV;
    else if (ro_evt)   cause = CAUSE_RO;
    else               cause = CAUSE_NONE;
  end

  assign fault = (cause != CAUSE_NONE);

  always_comb begin
    assert_single_cause_R8: assert ($onehot0({absent_evt, priv_evt, ro_evt}));
  end
endmodule

// File: rtl/ptw_read_port.sv
module ptw_read_port
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_resp_data
);
  port_st_t          st;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_hs;
  logic              data_hs;

  assign mem_req_valid = (st == RP_ADDR);
  assign mem_req_addr  = addr_q;
  assign addr_hs       = mem_req_valid && mem_req_ready;
  assign data_hs       = (st == RP_DATA) && mem_resp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= RP_IDLE;
      addr_q  <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RP_IDLE: if (start) begin
          st     <= RP_ADDR;
          addr_q <= start_addr;
        end
        RP_ADDR: if (addr_hs) st <= RP_DATA;
        RP_DATA: if (data_hs) begin
          rd_data <= mem_resp_data;
          done    <= 1'b1;
          st      <= RP_IDLE;
        end
        default: st <= RP_IDLE;
      endcase
    end
  end

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_start_when_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> st == RP_IDLE);

  assert_data_to_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_hs |=> done && !mem_req_valid);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_lin_addr,
  input  logic              req_user,
  input  logic              req_write,
  output logic              busy,
  input  logic [ADDR_W-1:0] root_base,
  input  logic              wp_enable,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_resp_valid,
  input  logic [ADDR_W-1:0] mem_resp_data,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  output logic              rsp_level,
  output logic [ADDR_W-1:0] rsp_phys_addr,
  output logic [ADDR_W-1:0] rsp_fault_addr
);
  localparam int TOP_LSB     = OFF_W + IDX_W;
  localparam int DIR_W       = ADDR_W - TOP_LSB;
  localparam int ENT_SZ_LOG  = 2;

  // address arithmetic
  function automatic logic [ADDR_W-1:0] dir_slot(input logic [ADDR_W-1:0] la);
    return ADDR_W'(la[ADDR_W-1:TOP_LSB]);
  endfunction

  function automatic logic [ADDR_W-1:0] tbl_slot(input logic [ADDR_W-1:0] la);
    return ADDR_W'(la[TOP_LSB-1:OFF_W]);
  endfunction

  function automatic logic [ADDR_W-1:0] frame_of(input logic [ADDR_W-1:0] e);
    return {e[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [ADDR_W-1:0] idx);
    return base + (idx << ENT_SZ_LOG);
  endfunction

  function automatic logic [ADDR_W-1:0] join_page(input logic [ADDR_W-1:0] e,
                                                  input logic [ADDR_W-1:0] la);
    return {e[ADDR_W-1:OFF_W], la[OFF_W-1:0]};
  endfunction

  walk_st_t          st;
  logic [ADDR_W-1:0] lin_q;
  logic              user_q, write_q, wp_q;
  logic              fault_q, level_q;
  cause_t            cause_q;
  logic [ADDR_W-1:0] phys_q, faddr_q;

  logic              rd_start, rd_done;
  logic [ADDR_W-1:0] rd_addr, rd_data;
  logic              chk_fault;
  cause_t            chk_cause;

  // named events for assertions
  logic accept_evt, dir_fault_evt, tbl_fault_evt, walk_ok_evt;
  logic unused_entry_bits;

  assign accept_evt    = (st == WK_IDLE) && req_valid;
  assign dir_fault_evt = (st == WK_DIR_CHK) && chk_fault;
  assign tbl_fault_evt = (st == WK_TBL_CHK) && chk_fault;
  assign walk_ok_evt   = (st == WK_TBL_CHK) && !chk_fault;
  assign unused_entry_bits = ^rd_data[OFF_W-1:FLAG_BITS];

  assign rd_start = accept_evt || ((st == WK_DIR_CHK) && !chk_fault);
  assign rd_addr  = (st == WK_IDLE)
                  ? slot_addr(root_base, dir_slot(req_lin_addr))
                  : slot_addr(frame_of(rd_data), tbl_slot(lin_q));

  ptw_read_port #(.ADDR_W(ADDR_W), .DATA_W(ADDR_W)) u_port (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (rd_start),
    .start_addr     (rd_addr),
    .done           (rd_done),
    .rd_data        (rd_data),
    .mem_req_valid  (mem_req_valid),
    .mem_req_addr   (mem_req_addr),
    .mem_req_ready  (mem_req_ready),
    .mem_resp_valid (mem_resp_valid),
    .mem_resp_data  (mem_resp_data)
  );

  ptw_rights u_rights (
    .flags    (rd_data[FLAG_BITS-1:0]),
    .is_user  (user_q),
    .is_write (write_q),
    .wp_en    (wp_q),
    .fault    (chk_fault),
    .cause    (chk_cause)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= WK_IDLE;
      lin_q   <= '0;
      user_q  <= 1'b0;
      write_q <= 1'b0;
      wp_q    <= 1'b0;
      fault_q <= 1'b0;
      level_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      phys_q  <= '0;
      faddr_q <= '0;
    end else begin
      case (st)
        WK_IDLE: if (accept_evt) begin
          lin_q   <= req_lin_addr;
          user_q  <= req_user;
          write_q <= req_write;
          wp_q    <= wp_enable;
          st      <= WK_DIR_RD;
        end
        WK_DIR_RD: if (rd_done) st <= WK_DIR_CHK;
        WK_DIR_CHK: begin
          if (chk_fault) begin
            fault_q <= 1'b1;
            level_q <= 1'b0;
            cause_q <= chk_cause;
            phys_q  <= '0;
            faddr_q <= lin_q;
            st      <= WK_RESP;
          end else begin
            st <= WK_TBL_RD;
          end
        end
        WK_TBL_RD: if (rd_done) st <= WK_TBL_CHK;
        WK_TBL_CHK: begin
          fault_q <= chk_fault;
          level_q <= chk_fault;
          cause_q <= chk_cause;
          phys_q  <= chk_fault ? '0 : join_page(rd_data, lin_q);
          faddr_q <= chk_fault ? lin_q : '0;
          st      <= WK_RESP;
        end
        WK_RESP: st <= WK_IDLE;
        default: st <= WK_IDLE;
      endcase
    end
  end

  assign busy           = (st != WK_IDLE);
  assign rsp_valid      = (st == WK_RESP);
  assign rsp_fault      = fault_q;
  assign rsp_cause      = cause_q;
  assign rsp_level      = level_q;
  assign rsp_phys_addr  = phys_q;
  assign rsp_fault_addr = faddr_q;

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy && !rsp_valid);

  assert_resp_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && !busy);

  assert_dir_fault_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dir_fault_evt |=> rsp_valid && rsp_fault && !rsp_level && !mem_req_valid);

  assert_tbl_fault_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_fault_evt |=> rsp_valid && rsp_fault && rsp_level);

  assert_fault_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

  assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_ok_evt |=> rsp_phys_addr[OFF_W-1:0] == lin_q[OFF_W-1:0]);

  assert_dir_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WK_DIR_RD) && mem_req_valid |->
      mem_req_addr == slot_addr(root_base, dir_slot(lin_q)));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !rsp_valid);

  // DIR_W documents the directory index width; tie it to the layout
  initial begin
    assert_layout_R3: assert (DIR_W > 0 && DIR_W + IDX_W + OFF_W == ADDR_W);
  end
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_user, req_write, wp_enable;
  logic [31:0] req_lin_addr, root_base;
  logic        busy;
  logic        mem_req_valid, mem_req_ready, mem_resp_valid;
  logic [31:0] mem_req_addr, mem_resp_data;
  logic        rsp_valid, rsp_fault, rsp_level;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_phys_addr, rsp_fault_addr;

  always #5 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin_addr(req_lin_addr),
    .req_user(req_user), .req_write(req_write), .busy(busy), .root_base(root_base),
    .wp_enable(wp_enable), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_level(rsp_level), .rsp_phys_addr(rsp_phys_addr),
    .rsp_fault_addr(rsp_fault_addr)
  );

  logic [31:0] mem [0:4095];
  int total = 0;
  int bad = 0;
  int nreads, nrsp, dly;
  bit pend;
  logic [31:0] cap, rd0, rd1;

  function automatic int widx(input logic [31:0] a);
    return int'(a[13:2]);
  endfunction

  // expected rights outcome: 0 ok, 1 absent, 2 privilege, 3 write-protect
  function automatic logic [1:0] rule(input logic [31:0] e, input bit u,
                                      input bit w, input bit wp);
    if (!e[0]) return 2'd1;
    if (u && !e[2]) return 2'd2;
    if (w && !e[1] && (u || !e[2] || wp)) return 2'd3;
    return 2'd0;
  endfunction

  function automatic string tag_of(input logic [1:0] c);
    case (c)
      2'd1: return "R6";
      2'd2: return "R7";
      2'd3: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // memory model: random address-ready and response delay
  initial begin
    mem_req_ready = 1'b0; mem_resp_valid = 1'b0; mem_resp_data = '0;
    pend = 0; nreads = 0; dly = 0; cap = '0;
    forever begin
      @(negedge clk);
      mem_resp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_resp_valid = 1'b1;
          mem_resp_data  = mem[widx(cap)];
          pend = 0;
        end else dly--;
      end else if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        pend = 1;
        dly = int'($urandom % 3);
        if (nreads == 0) rd0 = cap; else rd1 = cap;
        nreads++;
      end else if (mem_req_valid && rst_n) begin
        mem_req_ready = 1'($urandom % 2);
        cap = mem_req_addr;
      end
    end
  end

  initial begin
    nrsp = 0;
    forever begin
      @(negedge clk);
      if (rsp_valid) nrsp++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  task automatic walk(input logic [31:0] la, input bit u, input bit w,
                      input bit wp, input bit poke);
    logic [31:0] a0, a1, pde, pte;
    logic [1:0]  c0, c1;
    int start_rsp, waited;
    a0  = root_base + {20'd0, la[31:22], 2'b00};
    pde = mem[widx(a0)];
    c0  = rule(pde, u, w, wp);
    a1  = {pde[31:12], 12'h000} + {20'd0, la[21:12], 2'b00};
    pte = mem[widx(a1)];
    c1  = rule(pte, u, w, wp);
    while (busy) @(negedge clk);
    nreads = 0; start_rsp = nrsp;
    req_lin_addr = la; req_user = u; req_write = w; wp_enable = wp;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 busy after accept", {31'd0, busy}, 32'd1);
    if (poke) begin
      req_lin_addr = ~la; req_user = ~u; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    waited = 0;
    while (!rsp_valid && waited < 60) begin @(negedge clk); waited++; end
    if (!rsp_valid) begin
      total++; bad++;
      $display("FAIL R2: actual=no response expected=response");
      return;
    end
    chk("R3 dir read addr", rd0, a0);
    if (c0 != 0) begin
      chk({tag_of(c0), " dir cause"}, {30'd0, rsp_cause}, {30'd0, c0});
      chk("R9 dir level", {31'd0, rsp_level}, 32'd0);
      chk("R9 fault addr", rsp_fault_addr, la);
      chk("R9 no table read", nreads, 32'd1);
    end else begin
      chk("R4 table read addr", rd1, a1);
      chk({tag_of(c1), " table cause"}, {30'd0, rsp_cause}, {30'd0, c1});
      if (c1 != 0) begin
        chk("R9 table level", {31'd0, rsp_level}, 32'd1);
        chk("R9 fault addr", rsp_fault_addr, la);
      end else begin
        chk("R5 phys addr", rsp_phys_addr, {pte[31:12], la[11:0]});
        chk("R5 no fault", {31'd0, rsp_fault}, 32'd0);
      end
    end
    @(negedge clk);
    chk("R10 one-cycle response", {31'd0, rsp_valid}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R2 single response", nrsp - start_rsp, 32'd1);
    chk("R2 idle after walk", {31'd0, busy}, 32'd0);
  endtask

  function automatic logic [31:0] la_of(input int d, input int t, input int o);
    return {d[9:0], t[9:0], o[11:0]};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_user = 1'b0; req_write = 1'b0;
    wp_enable = 1'b0; req_lin_addr = '0; root_base = '0;
    for (int i = 0; i < 1024; i++)
      mem[i] = ((32'd1 + ($urandom % 3)) << 12) | ($urandom & 32'hff8) |
               {29'd0, 1'($urandom % 2), 1'($urandom % 2), 1'(($urandom % 10) != 0)};
    for (int i = 1024; i < 4096; i++)
      mem[i] = ($urandom & 32'hffff_fff8) |
               {29'd0, 1'($urandom % 2), 1'($urandom % 2), 1'(($urandom % 20) > 2)};
    // directed entries: dir 5 -> table 0x1000 (P|W|U), dir 6 -> (P|U),
    // dir 7 absent, dir 8 -> (P|W supervisor)
    mem[5] = 32'h0000_1007; mem[6] = 32'h0000_1005;
    mem[7] = 32'h0000_1006; mem[8] = 32'h0000_1003;
    mem[1024 + 9]  = 32'h0004_5005; // P|U read-only
    mem[1024 + 10] = 32'h0006_7001; // P supervisor read-only
    mem[1024 + 11] = 32'h0008_9006; // absent
    mem[1024 + 12] = 32'h000a_b007; // P|W|U
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 mem idle in reset", {31'd0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);

    walk(la_of(5, 9, 12'h123), 0, 1, 0, 0);   // R8 kernel write user RO, wp off: ok
    walk(la_of(5, 9, 12'h123), 0, 1, 1, 0);   // R8 same with wp on: fault
    walk(la_of(5, 10, 12'h004), 0, 1, 0, 0);  // R8 kernel write supervisor RO
    walk(la_of(5, 9, 12'hfff), 1, 1, 0, 0);   // R8 user write RO
    walk(la_of(5, 9, 12'h000), 1, 0, 0, 0);   // R5 user read ok
    walk(la_of(5, 10, 12'h010), 1, 0, 0, 0);  // R7 user read supervisor page
    walk(la_of(5, 11, 12'h020), 0, 0, 0, 0);  // R6 table absent
    walk(la_of(7, 12, 12'h030), 1, 1, 1, 0);  // R6 R9 directory absent
    walk(la_of(8, 12, 12'h040), 1, 0, 0, 0);  // R7 R9 directory privilege
    walk(la_of(6, 12, 12'h050), 0, 1, 0, 0);  // R8 dir RO kernel, wp off: ok
    walk(la_of(6, 12, 12'h050), 0, 1, 1, 1);  // R8 R9 dir-level write fault, poke R2
    root_base = 32'h0000_02a0;
    walk(la_of(1, 3, 12'h777), 0, 0, 0, 0);   // R3 offset root
    root_base = '0;
    for (int n = 0; n < 300; n++) begin
      if (n % 50 == 49) root_base = ($urandom % 4) << 10;
      walk($urandom, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
           ($urandom % 5) == 0);
    end
    finish_run();
  end
endmodule